// File: doc/BRIEF.md
# Scaler Job Control and Interrupt Unit

This block is the control core of a memory-to-memory image scaler. Software drives it over a simple word-addressed register bus. Through that bus it launches one frame job at a time on an external pixel engine, arms a watchdog that stops a job that hangs, and collects completion and error events into a pending-event register. A single level interrupt line tells the CPU that an enabled event is waiting.

A typical job runs as follows:

1. Software requests a self-clearing soft reset and polls until the reset bit drops.
2. It writes the interrupt mask and reads it back.
3. It programs the watchdog and issues a start command.
4. When the interrupt arrives, it reads the pending events and writes the same value back to acknowledge them.
5. The job counts as successful only when the frame-end event is among them.

The engine reports a one-cycle done pulse and a vector of parameter-error flags. These cover blend, ratio, and the width, height, position, span, base and colour settings on each side.

The register map uses word addresses:

| Address | Contents |
|---------|----------|
| 0 | Control and state |
| 1 | Interrupt mask |
| 2 | Pending events |
| 3 | Watchdog control |

Pending-event bit 0 is frame end and bit 1 is watchdog expiry. Bit 2+k mirrors engine error flag k. With the default 24 error flags there are 26 event bits in all.

Top module: `sclctl_top`

## Requirements
- R1: After the synchronous reset input, all four registers read 0, the interrupt output is low and the job state is idle.
- R2: Writing 1 to control bit 1 starts a soft reset. Control bit 1 then reads 1 for exactly RST_CYCLES clock edges after the write edge and clears by itself.
- R3: A soft reset clears the interrupt mask. Mask writes that land while the soft reset is in progress are ignored, and the first write after it completes is stored and read back.
- R4: Writing 1 to control bit 0 while idle launches a job. The design pulses eng_start_o for one cycle and reports the state in control bits 5:4 (0 idle, 1 running, 2 done). An engine done pulse while running sets event bit 0 and moves the state to done, then to idle on the next edge.
- R5: A start command issued while a job is running is ignored. No second eng_start_o pulse appears and the watchdog is not reloaded.
- R6: An engine error flag k that is high while a job runs sets event bit 2+k. Error flags and done pulses while idle leave the events unchanged.
- R7: Watchdog control holds the count in bits 15:0, the divider d in bits 19:16 and enable in bit 20. With enable set and count v, a running job without a done pulse is aborted after exactly v·2^d edges. The abort sets event bit 1 and pulses eng_abort_o.
- R8: Writing the pending-event register clears exactly the bits written as 1. Bits written as 0 keep their value.
- R9: The interrupt output is high one cycle after any event bit and its mask bit are both set, and stays high until that condition ends. A mask of 0 keeps it low.
- R10: A soft reset during a running job aborts it with an eng_abort_o pulse, returns the state to idle and clears all event bits.
- R11: With the watchdog enable bit at 0, a running job is never aborted by the watchdog.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after bus_rd |
| eng_done_i | input | 1 | Engine frame-complete pulse |
| eng_err_i | input | NERR | Engine parameter-error flags |
| eng_start_o | output | 1 | One-cycle job launch pulse |
| eng_abort_o | output | 1 | One-cycle job abort pulse |
| irq_o | output | 1 | Level interrupt request |

## Verification
The hardest situation to reach is a command colliding with a running job. This covers a second start landing mid-job, and a soft reset arriving while the watchdog is counting. The bench launches a job with a short watchdog and issues the competing command a fixed number of edges later. It then times the abort pulse from the original launch, which shows that neither the job nor the watchdog was restarted. The watchdog period is swept over divider and count pairs to pin the abort edge exactly. The mask write is placed on the last busy edge and on the first free edge of the soft reset.

// File: rtl/sclctl_pkg.sv
package sclctl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } sc_state_e;

  localparam int ADR_CTRL = 0;
  localparam int ADR_IEN  = 1;
  localparam int ADR_STAT = 2;
  localparam int ADR_TMO  = 3;

  localparam int CTL_START = 0;
  localparam int CTL_SRST  = 1;
  localparam int CTL_STATE = 4;

  localparam int SRC_FEND = 0;
  localparam int SRC_TMO  = 1;
  localparam int SRC_ERR0 = 2;
endpackage

// File: rtl/sclctl_softrst.sv
module sclctl_softrst #(
  parameter int RST_CYCLES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic go_i,
  output logic busy_o
);
  localparam int CW = $clog2(RST_CYCLES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o <= 1'b0;
      cnt_q  <= '0;
    end else if (go_i) begin
      busy_o <= 1'b1;
      cnt_q  <= CW'(RST_CYCLES);
    end else if (busy_o) begin
      if (cnt_q <= CW'(1)) begin
        busy_o <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q - CW'(1);
      end
    end
  end

  AST_RST_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> (cnt_q != '0) && (cnt_q <= CW'(RST_CYCLES))); // R2
endmodule

// File: rtl/sclctl_seq.sv
module sclctl_seq
  import sclctl_pkg::*;
#(
  parameter int TMR_W = 16,
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             srst_i,
  input  logic             start_i,
  input  logic             tmo_en_i,
  input  logic [TMR_W-1:0] tmo_val_i,
  input  logic [DIV_W-1:0] tmo_div_i,
  input  logic             eng_done_i,
  output sc_state_e        state_o,
  output logic             eng_start_o,
  output logic             eng_abort_o,
  output logic             fend_o,
  output logic             tmo_o
);
  localparam int PSC_W = (1 << DIV_W) - 1;

  logic [TMR_W-1:0] cnt_q;
  logic [PSC_W-1:0] psc_q;
  logic [PSC_W-1:0] psc_lim;
  logic             tick;
  logic             tmo_hit;
  logic             running;

  assign psc_lim = PSC_W'((64'd1 << tmo_div_i) - 64'd1);
  assign tick    = (psc_q == psc_lim);
  assign tmo_hit = tmo_en_i && tick && (cnt_q <= TMR_W'(1));
  assign running = (state_o == ST_RUN) && !srst_i;
  assign fend_o  = running && eng_done_i;
  assign tmo_o   = running && !eng_done_i && tmo_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_o     <= ST_IDLE;
      eng_start_o <= 1'b0;
      eng_abort_o <= 1'b0;
      cnt_q       <= '0;
      psc_q       <= '0;
    end else begin
      eng_start_o <= 1'b0;
      eng_abort_o <= 1'b0;
      if (srst_i) begin
        eng_abort_o <= (state_o == ST_RUN);
        state_o     <= ST_IDLE;
        psc_q       <= '0;
      end else begin
        case (state_o)
          ST_IDLE: begin
            if (start_i) begin
              state_o     <= ST_RUN;
              eng_start_o <= 1'b1;
              cnt_q       <= tmo_val_i;
              psc_q       <= '0;
            end
          end
          ST_RUN: begin
            if (eng_done_i) begin
              state_o <= ST_DONE;
            end else if (tmo_hit) begin
              state_o     <= ST_DONE;
              eng_abort_o <= 1'b1;
            end else if (tick) begin
              psc_q <= '0;
              if (tmo_en_i && cnt_q != '0) cnt_q <= cnt_q - TMR_W'(1);
            end else begin
              psc_q <= psc_q + PSC_W'(1);
            end
          end
          default: state_o <= ST_IDLE;
        endcase
      end
    end
  end

  AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
    eng_start_o |-> (state_o == ST_RUN) && ($past(state_o) == ST_IDLE)); // R5
  AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
    (state_o == ST_DONE) |=> (state_o == ST_IDLE)); // R4
endmodule

// File: rtl/sclctl_irq.sv
module sclctl_irq #(
  parameter int NSRC = 26
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr_all_i,
  input  logic            busy_i,
  input  logic            en_we_i,
  input  logic            st_w1c_i,
  input  logic [NSRC-1:0] wdata_i,
  input  logic [NSRC-1:0] set_i,
  output logic [NSRC-1:0] en_o,
  output logic [NSRC-1:0] stat_o,
  output logic            irq_o
);
  logic [NSRC-1:0] clr_mask;

  assign clr_mask = st_w1c_i ? wdata_i : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_o   <= '0;
      stat_o <= '0;
      irq_o  <= 1'b0;
    end else begin
      irq_o <= |(stat_o & en_o);
      if (clr_all_i) begin
        en_o   <= '0;
        stat_o <= '0;
      end else begin
        if (en_we_i && !busy_i) en_o <= wdata_i;
        stat_o <= (stat_o & ~clr_mask) | set_i;
      end
    end
  end

  AST_EN_LOCKED: assert property (@(posedge clk) disable iff (rst)
    busy_i |=> (en_o == '0)); // R3
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    ($past(en_o) == '0) |-> !irq_o); // R9
endmodule

// File: rtl/sclctl_top.sv
module sclctl_top
  import sclctl_pkg::*;
#(
  parameter int NERR       = 24,
  parameter int TMR_W      = 16,
  parameter int DIV_W      = 4,
  parameter int RST_CYCLES = 8,
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              eng_done_i,
  input  logic [NERR-1:0]   eng_err_i,
  output logic              eng_start_o,
  output logic              eng_abort_o,
  output logic              irq_o
);
  localparam int NSRC    = SRC_ERR0 + NERR;
  localparam int TMO_DIV = TMR_W;
  localparam int TMO_EN  = TMR_W + DIV_W;

  logic              wr_ctrl, wr_ien, wr_stat, wr_tmo;
  logic              srst_go, start_req, srst_busy;
  logic              fend, tmo;
  sc_state_e         state;
  logic [NSRC-1:0]   set_vec, ien, stat;
  logic [TMR_W-1:0]  tmo_val_q;
  logic [DIV_W-1:0]  tmo_div_q;
  logic              tmo_en_q;
  logic              unused_wdata;

  assign unused_wdata = ^bus_wdata[DATA_W-1:NSRC];

  assign wr_ctrl = bus_wr && (bus_addr == ADDR_W'(ADR_CTRL));
  assign wr_ien  = bus_wr && (bus_addr == ADDR_W'(ADR_IEN));
  assign wr_stat = bus_wr && (bus_addr == ADDR_W'(ADR_STAT));
  assign wr_tmo  = bus_wr && (bus_addr == ADDR_W'(ADR_TMO));

  assign srst_go   = wr_ctrl && bus_wdata[CTL_SRST] && !srst_busy;
  assign start_req = wr_ctrl && bus_wdata[CTL_START] && !bus_wdata[CTL_SRST] && !srst_busy;

  always_comb begin
    set_vec           = '0;
    set_vec[SRC_FEND] = fend;
    set_vec[SRC_TMO]  = tmo;
    set_vec[SRC_ERR0 +: NERR] = (state == ST_RUN) ? eng_err_i : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tmo_val_q <= '0;
      tmo_div_q <= '0;
      tmo_en_q  <= 1'b0;
    end else if (wr_tmo) begin
      tmo_val_q <= bus_wdata[TMR_W-1:0];
      tmo_div_q <= bus_wdata[TMO_DIV +: DIV_W];
      tmo_en_q  <= bus_wdata[TMO_EN];
    end
  end

  sclctl_softrst #(.RST_CYCLES(RST_CYCLES)) u_softrst (
    .clk    (clk),
    .rst    (rst),
    .go_i   (srst_go),
    .busy_o (srst_busy)
  );

  sclctl_seq #(.TMR_W(TMR_W), .DIV_W(DIV_W)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .srst_i      (srst_go),
    .start_i     (start_req),
    .tmo_en_i    (tmo_en_q),
    .tmo_val_i   (tmo_val_q),
    .tmo_div_i   (tmo_div_q),
    .eng_done_i  (eng_done_i),
    .state_o     (state),
    .eng_start_o (eng_start_o),
    .eng_abort_o (eng_abort_o),
    .fend_o      (fend),
    .tmo_o       (tmo)
  );

  sclctl_irq #(.NSRC(NSRC)) u_irq (
    .clk       (clk),
    .rst       (rst),
    .clr_all_i (srst_go),
    .busy_i    (srst_busy),
    .en_we_i   (wr_ien),
    .st_w1c_i  (wr_stat),
    .wdata_i   (bus_wdata[NSRC-1:0]),
    .set_i     (set_vec),
    .en_o      (ien),
    .stat_o    (stat),
    .irq_o     (irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= '0;
      case (bus_addr)
        ADDR_W'(ADR_CTRL): begin
          bus_rdata[CTL_SRST]       <= srst_busy;
          bus_rdata[CTL_STATE +: 2] <= state;
        end
        ADDR_W'(ADR_IEN):  bus_rdata[NSRC-1:0] <= ien;
        ADDR_W'(ADR_STAT): bus_rdata[NSRC-1:0] <= stat;
        ADDR_W'(ADR_TMO): begin
          bus_rdata[TMR_W-1:0]       <= tmo_val_q;
          bus_rdata[TMO_DIV +: DIV_W] <= tmo_div_q;
          bus_rdata[TMO_EN]           <= tmo_en_q;
        end
        default: bus_rdata <= '0;
      endcase
    end
  end

  AST_RST_CLEARS_STAT: assert property (@(posedge clk) disable iff (rst)
    $rose(srst_busy) |-> (stat == '0)); // R10
  AST_ABORT_FLAGGED: assert property (@(posedge clk) disable iff (rst)
    (eng_abort_o && !$past(srst_go)) |-> stat[SRC_TMO]); // R7
  AST_NO_START_IN_RST: assert property (@(posedge clk) disable iff (rst)
    srst_busy |-> (state == ST_IDLE) && !eng_start_o); // R10
endmodule

// File: tb/sclctl_top_tb.sv
module sclctl_top_tb;
  localparam int NERR = 24;
  localparam int RSTC = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        eng_done = 1'b0;
  logic [NERR-1:0] eng_err = '0;
  logic        eng_start, eng_abort, irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [31:0] rv;

  always #2 clk = ~clk;

  sclctl_top #(.NERR(NERR), .RST_CYCLES(RSTC)) u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_done_i(eng_done),
    .eng_err_i(eng_err), .eng_start_o(eng_start), .eng_abort_o(eng_abort), .irq_o(irq)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: act=%0d cycles exp=<150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = 4'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = 4'(a);
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic soft_reset_wait();
    wr(0, 32'h2);
    idle(RSTC + 1);
  endtask

  task automatic pulse_done();
    eng_done = 1'b1;
    @(negedge clk);
    eng_done = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(a, rv);
      chk("R1", rv, 32'h0);
    end
    chk("R1 irq", {31'b0, irq}, 32'h0);

    // R2 self-clearing soft reset, exact width
    wr(0, 32'h2);
    for (int j = 1; j <= RSTC + 1; j++) begin
      rd(0, rv);
      chk("R2", {31'b0, rv[1]}, (j <= RSTC) ? 32'h1 : 32'h0);
    end

    // R3 mask write on last busy edge is dropped, first free edge accepted
    wr(0, 32'h2);
    idle(RSTC - 1);
    wr(1, 32'h1);
    rd(1, rv);
    chk("R3 blocked", rv, 32'h0);
    wr(0, 32'h2);
    idle(RSTC);
    wr(1, 32'h1);
    rd(1, rv);
    chk("R3 accepted", rv, 32'h1);
    soft_reset_wait();
    rd(1, rv);
    chk("R3 cleared", rv, 32'h0);

    // R4 job launch, done, state sequence
    wr(0, 32'h1);
    chk("R4 start pulse", {31'b0, eng_start}, 32'h1);
    rd(0, rv);
    chk("R4 running", {30'b0, rv[5:4]}, 32'h1);
    chk("R4 single pulse", {31'b0, eng_start}, 32'h0);
    pulse_done();
    rd(0, rv);
    chk("R4 done state", {30'b0, rv[5:4]}, 32'h2);
    rd(2, rv);
    chk("R4 frame end", rv, 32'h1);
    rd(0, rv);
    chk("R4 idle", {30'b0, rv[5:4]}, 32'h0);

    // R8 write-one-to-clear with several bits pending
    wr(2, 32'h1);
    wr(0, 32'h1);
    eng_err = 24'h28;
    @(negedge clk);
    eng_err = '0;
    pulse_done();
    rd(2, rv);
    chk("R6 multi", rv, 32'hA1);
    wr(2, 32'h0);
    rd(2, rv);
    chk("R8 zero write", rv, 32'hA1);
    wr(2, 32'h20);
    rd(2, rv);
    chk("R8 partial", rv, 32'h81);
    wr(2, 32'h81);
    rd(2, rv);
    chk("R8 rest", rv, 32'h0);

    // R6 per-flag sweep
    for (int k = 0; k < NERR; k++) begin
      wr(0, 32'h1);
      eng_err = NERR'(1) << k;
      @(negedge clk);
      eng_err = '0;
      pulse_done();
      rd(2, rv);
      chk("R6", rv, (32'h1 << (2 + k)) | 32'h1);
      wr(2, 32'hFFFF_FFFF);
    end
    eng_err = '1;
    eng_done = 1'b1;
    idle(2);
    eng_err = '0;
    eng_done = 1'b0;
    rd(2, rv);
    chk("R6 idle ignored", rv, 32'h0);

    // R7 watchdog sweep
    for (int d = 0; d < 4; d++) begin
      for (int v = 1; v <= 5; v++) begin
        int k;
        wr(3, 32'(1 << 20) | 32'(d << 16) | 32'(v));
        wr(0, 32'h1);
        k = 0;
        while (!eng_abort && k < 1000) begin
          @(negedge clk);
          k++;
        end
        chk("R7 abort edge", 32'(k), 32'(v * (1 << d)));
        rd(2, rv);
        chk("R7 timeout bit", rv, 32'h2);
        wr(2, 32'h2);
      end
    end
    rd(3, rv);
    chk("R7 readback", rv, 32'h0013_0005);

    // R5 start while running is ignored (no reload, no pulse)
    begin
      int k;
      int starts;
      wr(3, 32'h0010_000A);
      wr(0, 32'h1);
      k = 0;
      starts = 1;
      idle(4);
      k = 4;
      wr(0, 32'h1);
      k = 5;
      if (eng_start) starts++;
      while (!eng_abort && k < 1000) begin
        @(negedge clk);
        k++;
        if (eng_start) starts++;
      end
      chk("R5 no second start", 32'(starts), 32'h1);
      chk("R5 no reload", 32'(k), 32'd10);
      wr(2, 32'hFFFF_FFFF);
    end

    // R11 watchdog disabled
    begin
      int aborts;
      aborts = 0;
      wr(3, 32'h0000_0001);
      wr(0, 32'h1);
      for (int i = 0; i < 100; i++) begin
        @(negedge clk);
        if (eng_abort) aborts++;
      end
      chk("R11 no abort", 32'(aborts), 32'h0);
      rd(0, rv);
      chk("R11 still running", {30'b0, rv[5:4]}, 32'h1);
      pulse_done();
      idle(1);
      wr(2, 32'hFFFF_FFFF);
    end

    // R9 interrupt level and masking
    wr(1, 32'h1);
    wr(0, 32'h1);
    eng_err = 24'h1;
    @(negedge clk);
    eng_err = '0;
    pulse_done();
    idle(1);
    chk("R9 irq set", {31'b0, irq}, 32'h1);
    idle(5);
    chk("R9 irq held", {31'b0, irq}, 32'h1);
    wr(2, 32'h1);
    idle(1);
    chk("R9 irq drop", {31'b0, irq}, 32'h0);
    wr(1, 32'h4);
    idle(1);
    chk("R9 other source", {31'b0, irq}, 32'h1);
    wr(1, 32'h0);
    idle(1);
    chk("R9 mask zero", {31'b0, irq}, 32'h0);
    wr(2, 32'hFFFF_FFFF);

    // R10 soft reset aborts a running job
    wr(3, 32'h0010_0100);
    wr(0, 32'h1);
    eng_err = 24'h2;
    @(negedge clk);
    eng_err = '0;
    wr(0, 32'h2);
    chk("R10 abort pulse", {31'b0, eng_abort}, 32'h1);
    idle(RSTC + 1);
    rd(0, rv);
    chk("R10 idle", {30'b0, rv[5:4]}, 32'h0);
    rd(2, rv);
    chk("R10 stat cleared", rv, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule